// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Shared Speculative Terms

This block is a purely combinational adder of two W-bit operands and a carry input, meant as the last carry-propagate stage of a tree multiplier. The word is cut into blocks whose widths grow towards the most significant end: 2, 2, 3, 4 and 5 bits for the default W of 16. A later block has more bits, but its carry input also settles later. The growing widths let each block finish its internal work at about the time its carry input arrives.

Each bit forms one XOR, one AND and one OR of its operand bits. Both speculative results of the bit come from these shared terms. For an incoming carry of 0, the sum is the XOR and the carry is the AND. For an incoming carry of 1, the sum is the inverted XOR and the carry is the OR. No second adder is built. Inside a block, a chain of multiplexers walks these terms twice: once assuming the block's carry input is 0 and once assuming it is 1. The real block carry then picks one of the two rails. The lowest block has no speculation and uses the adder's carry input directly. The carry out of the top block is the adder's carry output.

There is no state machine, clock or reset. The house layout is kept for naming and for the separate checker.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, {cout, sum} equals a + b + cin computed to W+1 bits. cout is the carry out of the most significant bit.
- R2: For W=16 the blocks start at bit positions 0, 2, 4, 7 and 11. The carry entering each block (bits 2, 4, 7 and 11) equals the arithmetic carry of the lower bits, so a carry made just below a boundary appears in the next bit.
- R3: When every bit position propagates (a XOR b all ones), sum is all ones with cout=0 for cin=0, and sum is all zeros with cout=1 for cin=1. In both cases cin crosses every block.
- R4: With a and b both all ones and cin=1, sum is all ones and cout is 1.
- R5: With b=0 and cin=0, sum equals a and cout is 0. With all inputs zero, the outputs are zero.
- R6: A carry generated at bit 0, with every higher bit propagating, gives sum = {zeros, cin} and cout=1. This carry runs across every block boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of the result |
| cout | output | 1 | Carry out of the top bit |

## Verification
The checker re-evaluates the arithmetic result, each carry at a block boundary, and the propagate-everywhere, all-ones, zero-operand and long-carry cases on every input change. The carry at each of the four block boundaries is compared with the true partial-sum carry, which the output ports do not show directly. Only the bench's scenarios show that these relations hold for particular patterns: alternating bits, a carry made exactly at a boundary, and a carry that ripples from bit 0 to the top. The bench also covers a long run of random operands.

// File: rtl/srsa_pkg.sv
package srsa_pkg;

    // Nominal width of block k: two blocks of 2, then growing by one.
    function automatic int nominal_size(input int k);
        return (k < 2) ? 2 : k + 1;
    endfunction

    // Number of blocks needed to cover w bits.
    function automatic int blk_count(input int w);
        int tot;
        int n;
        tot = 0;
        n = 0;
        while (tot < w) begin
            tot = tot + nominal_size(n);
            n = n + 1;
        end
        return n;
    endfunction

    // Lowest bit position of block k.
    function automatic int blk_base(input int w, input int k);
        int tot;
        tot = 0;
        for (int i = 0; i < k; i++) begin
            tot = tot + nominal_size(i);
        end
        return (tot > w) ? w : tot;
    endfunction

    // Width of block k; the last block takes the remainder.
    function automatic int blk_size(input int w, input int k);
        if (k == blk_count(w) - 1) begin
            return w - blk_base(w, k);
        end
        return nominal_size(k);
    endfunction

endpackage

// File: rtl/srsa_cell.sv
module srsa_cell (
    input  logic a_i,
    input  logic b_i,
    output logic s0_o,
    output logic s1_o,
    output logic c0_o,
    output logic c1_o
);
    logic half_sum;

    always_comb begin
        half_sum = a_i ^ b_i;
        s0_o     = half_sum;
        s1_o     = ~half_sum;
        c0_o     = a_i & b_i;
        c1_o     = a_i | b_i;
    end
endmodule

// File: rtl/srsa_rail.sv
module srsa_rail #(
    parameter int N = 2
) (
    input  logic [N-1:0] s0_i,
    input  logic [N-1:0] s1_i,
    input  logic [N-1:0] c0_i,
    input  logic [N-1:0] c1_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    logic [N:0] chain;

    always_comb begin
        chain[0] = cin_i;
        for (int i = 0; i < N; i++) begin
            sum_o[i]   = chain[i] ? s1_i[i] : s0_i[i];
            chain[i+1] = chain[i] ? c1_i[i] : c0_i[i];
        end
        cout_o = chain[N];
    end
endmodule

// File: rtl/srsa_block.sv
module srsa_block #(
    parameter int N     = 2,
    parameter bit FIRST = 1'b0
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    logic [N-1:0] s0, s1, c0, c1;

    for (genvar i = 0; i < N; i++) begin : g_cell
        srsa_cell u_cell (
            .a_i  (a_i[i]),
            .b_i  (b_i[i]),
            .s0_o (s0[i]),
            .s1_o (s1[i]),
            .c0_o (c0[i]),
            .c1_o (c1[i])
        );
    end

    if (FIRST) begin : g_direct
        srsa_rail #(.N(N)) u_rail (
            .s0_i   (s0),
            .s1_i   (s1),
            .c0_i   (c0),
            .c1_i   (c1),
            .cin_i  (cin_i),
            .sum_o  (sum_o),
            .cout_o (cout_o)
        );
    end else begin : g_spec
        logic [N-1:0] sum_lo, sum_hi;
        logic         cy_lo, cy_hi;

        srsa_rail #(.N(N)) u_rail0 (
            .s0_i   (s0),
            .s1_i   (s1),
            .c0_i   (c0),
            .c1_i   (c1),
            .cin_i  (1'b0),
            .sum_o  (sum_lo),
            .cout_o (cy_lo)
        );
        srsa_rail #(.N(N)) u_rail1 (
            .s0_i   (s0),
            .s1_i   (s1),
            .c0_i   (c0),
            .c1_i   (c1),
            .cin_i  (1'b1),
            .sum_o  (sum_hi),
            .cout_o (cy_hi)
        );

        always_comb begin
            sum_o  = cin_i ? sum_hi : sum_lo;
            cout_o = cin_i ? cy_hi  : cy_lo;
        end
    end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NB = srsa_pkg::blk_count(W);

    logic [NB:0] blk_c;

    assign blk_c[0] = cin;

    for (genvar k = 0; k < NB; k++) begin : g_blk
        localparam int LO = srsa_pkg::blk_base(W, k);
        localparam int SZ = srsa_pkg::blk_size(W, k);

        srsa_block #(.N(SZ), .FIRST(k == 0)) u_blk (
            .a_i    (a[LO +: SZ]),
            .b_i    (b[LO +: SZ]),
            .cin_i  (blk_c[k]),
            .sum_o  (sum[LO +: SZ]),
            .cout_o (blk_c[k+1])
        );
    end

    assign cout = blk_c[NB];
endmodule

// File: rtl/srsa_check.sv
module srsa_check #(
    parameter int W  = 16,
    parameter int NB = 5
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         cin,
    input logic [W-1:0] sum,
    input logic         cout,
    input logic [NB:0]  blk_c
);
    logic [W:0] full_ref;
    logic [W:0] part_ref;
    logic [W:0] msk;

    always_comb begin
        full_ref = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        assert_sum_R1: assert ({cout, sum} == full_ref)
            else $error("R1 result mismatch");

        for (int k = 1; k < NB; k++) begin
            msk      = ({{W{1'b0}}, 1'b1} << srsa_pkg::blk_base(W, k)) - 1'b1;
            part_ref = ({1'b0, a} & msk) + ({1'b0, b} & msk) + {{W{1'b0}}, cin};
            assert_boundary_R2: assert (blk_c[k] == part_ref[srsa_pkg::blk_base(W, k)])
                else $error("R2 block carry mismatch");
        end

        if ((a ^ b) == {W{1'b1}}) begin
            assert_propagate_R3: assert (sum == {W{~cin}} && cout == cin)
                else $error("R3 propagate case");
        end

        if ((a & b) == {W{1'b1}} && cin) begin
            assert_allones_R4: assert (sum == {W{1'b1}} && cout)
                else $error("R4 all ones case");
        end

        if (b == '0 && !cin) begin
            assert_zero_R5: assert (sum == a && !cout)
                else $error("R5 zero operand case");
        end

        if (a[0] && b[0] && (a[W-1:1] ^ b[W-1:1]) == {(W-1){1'b1}}) begin
            assert_longcarry_R6: assert (sum == {{(W-1){1'b0}}, cin} && cout)
                else $error("R6 long carry case");
        end
    end
endmodule

bind sqrt_csel_adder srsa_check #(.W(W), .NB(NB)) u_chk (
    .a     (a),
    .b     (b),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .blk_c (blk_c)
);

// File: tb/sim_sqrt_csel_adder.sv
module sim_sqrt_csel_adder;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int NV = 10;
    localparam int NRAND = 300;

    // {a, b, cin}
    localparam logic [2*W:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b1},
        {16'hAAAA, 16'h5555, 1'b0},
        {16'hAAAA, 16'h5555, 1'b1},
        {16'hAAAA, 16'hAAAA, 1'b0},
        {16'h5555, 16'h5555, 1'b1},
        {16'h1234, 16'h4321, 1'b0},
        {16'h8000, 16'h8000, 1'b0},
        {16'h0003, 16'h0001, 1'b1},
        {16'h7FFF, 16'h0001, 1'b0}
    };

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;
    int           n_checks = 0;
    int           n_errors = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sqrt_csel_adder #(.W(W)) u0 (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    task automatic check_add(input logic [W-1:0] x, input logic [W-1:0] y,
                             input logic c, input string tag);
        logic [W:0] expv;
        @(posedge clk);
        a   = x;
        b   = y;
        cin = c;
        @(negedge clk);
        expv = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        n_checks++;
        if ({cout, sum} !== expv) begin
            n_errors++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                     tag, x, y, c, {cout, sum}, expv);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R1 actual=timeout expected=complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // Quiet state: all inputs zero gives zero outputs (R5)
        @(negedge clk);
        n_checks++;
        if (sum !== '0 || cout !== 1'b0) begin
            n_errors++;
            $display("FAIL R5 idle actual=%h expected=%h", {cout, sum}, 17'h0);
        end

        // Table walk (R1)
        for (int i = 0; i < NV; i++) begin
            check_add(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0], "R1 table");
        end

        // Carry made just below each block boundary (R2): bits 2,4,7,11
        check_add(16'h0002, 16'h0002, 1'b0, "R2 boundary bit2");
        check_add(16'h0008, 16'h0008, 1'b0, "R2 boundary bit4");
        check_add(16'h0040, 16'h0040, 1'b0, "R2 boundary bit7");
        check_add(16'h0400, 16'h0400, 1'b0, "R2 boundary bit11");
        check_add(16'h007F, 16'h0000, 1'b1, "R2 ripple into bit7");
        check_add(16'h07FF, 16'h0000, 1'b1, "R2 ripple into bit11");

        // Propagate everywhere (R3)
        check_add(16'hF0F0, 16'h0F0F, 1'b1, "R3 propagate cin1");
        check_add(16'hF0F0, 16'h0F0F, 1'b0, "R3 propagate cin0");
        check_add(16'h0000, 16'hFFFF, 1'b1, "R3 zero plus ones");

        // All ones with carry in (R4)
        check_add(16'hFFFF, 16'hFFFF, 1'b1, "R4 all ones");

        // Zero operand (R5)
        check_add(16'hBEEF, 16'h0000, 1'b0, "R5 zero b");
        check_add(16'h0000, 16'h0000, 1'b0, "R5 all zero");

        // Generate at bit 0, propagate above (R6)
        check_add(16'h0001, 16'hFFFF, 1'b0, "R6 long carry cin0");
        check_add(16'hFFFF, 16'h0001, 1'b1, "R6 long carry cin1");
        check_add(16'hAAAB, 16'h5555, 1'b0, "R6 alternating long carry");

        // Random operands (R1)
        for (int i = 0; i < NRAND; i++) begin
            check_add(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule